// File: doc/BRIEF.md
# Isochronous Resource Register File

This block holds the four shared resource registers that the isochronous resource manager node of a serial bus keeps for the other nodes. The first register names the current bus manager. The second counts the isochronous bandwidth still free. The last two are channel masks that together give one bit to each of 64 channels. Other nodes claim and return resources without any lock. Each node reads a register, then issues a compare-swap that only lands if nobody changed the value in between.

The request port carries an operation, a quadlet offset, a compare value and a new-data value. One request may arrive per cycle. The block answers exactly one cycle later with the register's prior contents, or with an error flag for an offset that maps to nothing. A bus reset input puts all four registers back to their idle values, and a parameter gives the bandwidth value used at that reset.

Top module: `iso_resource_regs`

## Requirements
- R1: After `rst_n` is released, a read returns 0x3F at offset 0 (no manager), `BW_MAX` (default 4915) at offset 1, and 0xFFFFFFFF at offsets 2 and 3.
- R2: A request with `req_op`=0 (read) is answered one cycle after it is accepted. The answer has `resp_valid`=1, `resp_err`=0 and the register's current value, and no state changes. Offset 0 is the manager ID, 1 is bandwidth, 2 is the channel mask for channels 0–31 and 3 is the mask for channels 32–63.
- R3: A compare-swap (`req_op`=1) whose compare value equals the register replaces the register with the new data. Its answer, one cycle later, carries the value from before the swap.
- R4: A compare-swap whose compare value differs from the register leaves the register unchanged, and its answer still carries the current value.
- R5: The manager ID is 6 bits wide and the bandwidth 13 bits wide. Bits above those widths read as zero, are ignored in the compare, and are dropped from the new data.
- R6: A request to any offset from 4 to 15 is answered with `resp_err`=1 and `resp_data`=0, and no register changes.
- R7: While `bus_reset` is high, all registers return to the R1 values. A request in the same cycle is dropped, so no response follows it.
- R8: Compare-swaps in consecutive cycles are applied in order. The second sees the result of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | Synchronous reinitialisation after a bus reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = read, 1 = compare-swap |
| req_addr | input | 4 | Quadlet offset |
| req_cmp | input | 32 | Compare value |
| req_new | input | 32 | New data |
| resp_valid | output | 1 | Response present |
| resp_err | output | 1 | Offset is unmapped |
| resp_data | output | 32 | Prior register contents |

## Verification
The hardest case is atomicity under contention. Two swaps land in back-to-back cycles, and the second one's compare value is the first one's new data, so it can only succeed if the first swap has already been committed. The bench issues that pair with no idle cycle between them and checks both prior values. The other hard case is a bus reset that arrives together with a swap. The bench overlaps the two, checks that no response follows, and then reads every register back.

// File: rtl/iso_resource_regs.sv
module iso_resource_regs #(
  parameter int ID_W   = 6,
  parameter int BW_W   = 13,
  parameter int BW_MAX = 4915,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_cmp,
  input  logic [DATA_W-1:0] req_new,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_data
);
  localparam logic [BW_W-1:0]   BW_RST  = BW_W'(BW_MAX);
  localparam logic [DATA_W-1:0] ID_MASK = DATA_W'({ID_W{1'b1}});
  localparam logic [DATA_W-1:0] BW_MASK = DATA_W'({BW_W{1'b1}});

  logic [ID_W-1:0]   mgr_id;
  logic [BW_W-1:0]   bw_avail;
  logic [DATA_W-1:0] chan_lo, chan_hi;
  logic [DATA_W-1:0] cur, mask;

  wire hit    = (req_addr[ADDR_W-1:2] == '0);
  wire accept = req_valid && !bus_reset;

  always_comb begin
    case (req_addr[1:0])
      2'd0:    begin cur = DATA_W'(mgr_id);   mask = ID_MASK; end
      2'd1:    begin cur = DATA_W'(bw_avail); mask = BW_MASK; end
      2'd2:    begin cur = chan_lo;           mask = '1;      end
      default: begin cur = chan_hi;           mask = '1;      end
    endcase
  end

  wire match   = ((cur ^ req_cmp) & mask) == '0;
  wire do_swap = accept && hit && req_op && match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mgr_id   <= '1;
      bw_avail <= BW_RST;
      chan_lo  <= '1;
      chan_hi  <= '1;
    end else if (bus_reset) begin
      mgr_id   <= '1;
      bw_avail <= BW_RST;
      chan_lo  <= '1;
      chan_hi  <= '1;
    end else if (do_swap) begin
      case (req_addr[1:0])
        2'd0:    mgr_id   <= req_new[ID_W-1:0];
        2'd1:    bw_avail <= req_new[BW_W-1:0];
        2'd2:    chan_lo  <= req_new;
        default: chan_hi  <= req_new;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= accept;
      resp_err   <= accept && !hit;
      resp_data  <= hit ? cur : '0;
    end
  end

  p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid);
  p_no_spurious_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !resp_valid);
  p_id_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_addr == '0) |=> (resp_data[DATA_W-1:ID_W] == '0));
  p_err_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> ($stable(mgr_id) && $stable(bw_avail) && $stable(chan_lo) && $stable(chan_hi)));
  p_miss_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && req_op && !match) |=> ($stable(mgr_id) && $stable(bw_avail) && $stable(chan_lo) && $stable(chan_hi)));
  p_read_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_op) |=> ($stable(mgr_id) && $stable(bw_avail) && $stable(chan_lo) && $stable(chan_hi)));
  p_bus_reset_values_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (mgr_id == '1 && bw_avail == BW_RST && chan_lo == '1 && chan_hi == '1));
  p_err_data_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_valid && resp_data == '0));
endmodule

// File: tb/iso_resource_regs_tb.sv
module iso_resource_regs_tb;
  localparam int BW_MAX = 4915;
  logic clk = 0, rst_n = 0, bus_reset = 0;
  logic req_valid = 0, req_op = 0;
  logic [3:0] req_addr = 0;
  logic [31:0] req_cmp = 0, req_new = 0;
  logic resp_valid, resp_err;
  logic [31:0] resp_data;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];
  logic [31:0] m_reg [4];

  always #2.5 clk = ~clk;

  iso_resource_regs #(.BW_MAX(BW_MAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_cmp(req_cmp), .req_new(req_new),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data));

  function automatic logic [31:0] wmask(int a);
    return a == 0 ? 32'h3F : a == 1 ? 32'h1FFF : 32'hFFFF_FFFF;
  endfunction

  task automatic model_reset();
    m_reg[0] = 32'h3F; m_reg[1] = BW_MAX; m_reg[2] = '1; m_reg[3] = '1;
  endtask

  task automatic send(input logic op, input int a, input logic [31:0] c,
                      input logic [31:0] n, input string tag);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = 4'(a); req_cmp = c; req_new = n;
    if (a > 3) begin
      q_data.push_back(0); q_err.push_back(1); q_tag.push_back(tag);
    end else begin
      q_data.push_back(m_reg[a]); q_err.push_back(0); q_tag.push_back(tag);
      if (op && ((m_reg[a] ^ c) & wmask(a)) == 0) m_reg[a] = n & wmask(a);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); req_valid = 0; end
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  always begin
    @(posedge clk); #1;
    if (resp_valid) begin
      if (q_data.size() == 0)
        check(0, "R7 unexpected response", resp_data, 0);
      else begin
        logic [31:0] ed; logic ee; string t;
        ed = q_data.pop_front(); ee = q_err.pop_front(); t = q_tag.pop_front();
        check(resp_data == ed && resp_err == ee, t, {resp_err, resp_data[30:0]}, {ee, ed[30:0]});
      end
    end
  end

  task automatic read_all(string tag);
    for (int a = 0; a < 4; a++) send(0, a, 0, 0, tag);
    idle(2);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(resp_valid == 0, "R1 no response in reset", {31'b0, resp_valid}, 0);
    rst_n = 1;
    read_all("R1 R2 reset values");
    send(1, 1, BW_MAX, BW_MAX - 115, "R3 bandwidth swap");
    send(0, 1, 0, 0, "R3 bandwidth after swap");
    send(1, 1, 32'd1000, 32'd7, "R4 bandwidth miss");
    send(0, 1, 0, 0, "R4 bandwidth unchanged");
    send(1, 0, 32'hFFFF_FF3F, 32'hABCD_0005, "R5 id swap ignores upper bits");
    send(0, 0, 0, 0, "R5 id reads zero-extended");
    send(1, 1, 32'hFFFF_0000 | (BW_MAX - 115), 32'hFFFF_1234, "R5 bandwidth upper ignored");
    send(0, 1, 0, 0, "R5 bandwidth upper dropped");
    send(1, 3, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R3 channel 63 claim");
    send(1, 3, 32'hFFFF_FFFF, 32'h0, "R4 channel claim stale compare");
    idle(2);
    send(1, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R8 first back-to-back swap");
    send(1, 2, 32'hFFFF_FFFE, 32'hFFFF_FFFC, "R8 second sees first");
    send(0, 2, 0, 0, "R8 final mask");
    idle(2);
    send(1, 5, 32'h3F, 32'h0, "R6 unmapped swap");
    send(0, 15, 0, 0, "R6 unmapped read");
    idle(1);
    read_all("R6 registers unchanged");
    @(negedge clk);
    bus_reset = 1; req_valid = 1; req_op = 1; req_addr = 0; req_cmp = 32'h5; req_new = 32'h9;
    model_reset();
    @(negedge clk);
    bus_reset = 0; req_valid = 0;
    check(resp_valid == 0, "R7 request dropped at bus reset", {31'b0, resp_valid}, 0);
    read_all("R7 values after bus reset");
    idle(3);
    check(q_data.size() == 0, "R2 every request answered", q_data.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule